// File: doc/BRIEF.md
# Write-and-Verify Serial Sequencer

This block is the master side of a link to a three-wire shift-register peripheral, such as a dual digital potentiometer. After reset it runs one fixed program with no outside help. It frames three transactions of three bytes each with an enable line. The first transaction clears the peripheral with zero bytes. The second writes a target frame. The third sends the same frame again while it checks what the peripheral shifts back. The serial clock idles low and runs at the system clock divided by a parameter. Bytes go out most significant bit first.

The peripheral keeps only the last 17 bits it received, and it returns them in the order they arrived, followed by 7 pad bits. The expected readback is therefore the written frame with its leading 7 bits dropped and the remainder shifted into the first 17 bit positions. The first two returned bytes must match in full. In the third byte only the most significant bit holds data, so only that bit is compared.

The result appears on an active-low LED. The LED stays lit once every check has passed. It blinks with a parameterised half period after any mismatch, and that mismatch also cuts the transaction short.

Top module: `spi_verify_seq`

## Requirements
- R1: While reset is held and just after it is released, ledN is 1 (LED off), spiEn is 0, sclk is 0 and mosi is 0.
- R2: Each bit lasts CLK_DIV system clocks. sclk is low for the first half of the bit and high for the second half. mosi holds the bit for the whole bit time and changes only when sclk falls or when a byte is loaded.
- R3: spiEn rises at least one system clock before the first sclk rising edge of a transaction. It falls after the last bit of the third byte. sclk never rises while spiEn is low.
- R4: The three transactions send the bytes 00h 00h 00h, then 01h FFh 80h, then 01h FFh 80h, with each byte sent MSB first.
- R5: A byte is loaded only after the previous byte has finished all 8 bits. The gap between the last sclk rise of one byte and the first rise of the next is longer than one bit time.
- R6: Each received bit is sampled from miso at the end of its bit time, just before sclk falls. The bits are assembled MSB first.
- R7: In the third transaction, received byte 0 must equal FFh and received byte 1 must equal C0h. A difference in any of these 16 bits causes failure.
- R8: In the third transaction, only bit 7 of received byte 2 is checked, and it must be 0. Bits 6 to 0 of that byte have no effect on the result.
- R9: A mismatch ends the transaction right after the byte that failed. spiEn falls and no further sclk edges occur, so the total count of sclk rises is 48 + 8·(failing byte index + 1).
- R10: When all checks pass, spiEn falls after 72 sclk rises and ledN goes to 0 and stays at 0.
- R11: On failure ledN goes to 0 and then toggles every BLINK_HALF system clocks, without end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| miso | input | 1 | Serial data returned by the peripheral |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data sent to the peripheral |
| spiEn | output | 1 | Transaction enable, high while a three-byte frame is in progress |
| ledN | output | 1 | Active-low status LED: steady on for pass, blinking for fail |

## Verification
The assertions check several rules on every cycle. mosi stays steady while sclk is high. A byte is loaded only when the shifter is idle. sclk rises only inside an enabled frame. The enable drops only between bytes. The pass LED holds steady, and every blink toggle lands exactly on the half-period count. The bench's scenarios show the rest. They check the byte contents of the three transactions, the bit timing seen from the pins, and the mapping from each of the 24 readback bit positions to pass or fail. A slave model corrupts each position in turn, so the masked pad bits and the abort point can only be confirmed through these whole-sequence runs.

// File: rtl/spi_verify_pkg.sv
package spi_verify_pkg;
  localparam int BYTE_W = 8;

  // control -> datapath strobes
  typedef struct packed {
    logic              load;
    logic [BYTE_W-1:0] txByte;
  } xferCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic              done;
    logic              busy;
    logic [BYTE_W-1:0] rxByte;
  } xferStat_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_LOAD, ST_WAIT, ST_CLOSE, ST_PASS, ST_FAIL
  } seqState_t;

  typedef enum logic [1:0] {
    PH_CLEAR, PH_WRITE, PH_VERIFY
  } phase_t;
endpackage

// File: rtl/spi_shift_dp.sv
module spi_shift_dp
  import spi_verify_pkg::*;
#(
  parameter int CLK_DIV = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  xferCmd_t  cmd,
  output xferStat_t stat,
  output logic      sclk,
  output logic      mosi,
  input  logic      miso
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic              busy;
  logic              done;
  logic              bitEnd;

  assign bitEnd = busy && (divCnt == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      bitCnt  <= '0;
      txShift <= '0;
      rxShift <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd.load && !busy) begin
        txShift <= cmd.txByte;
        busy    <= 1'b1;
        divCnt  <= '0;
        bitCnt  <= '0;
      end else if (bitEnd) begin
        divCnt  <= '0;
        rxShift <= {rxShift[BYTE_W-2:0], miso};
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
        if (bitCnt == BIT_W'(BYTE_W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else if (busy) begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign sclk        = busy && (divCnt >= DIV_W'(HALF));
  assign mosi        = txShift[BYTE_W-1];
  assign stat.done   = done;
  assign stat.busy   = busy;
  assign stat.rxByte = rxShift;

  // R2: data held steady across the high phase of sclk
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R5: a new byte is only accepted by an idle shifter
  p_load_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> !busy);

  // R6: completion follows a busy byte and leaves the shifter idle
  p_done_from_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    stat.done |-> (!busy && $past(busy)));
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_verify_pkg::*;
#(
  parameter logic [7:0] FRAME0     = 8'h01,
  parameter logic [7:0] FRAME1     = 8'hFF,
  parameter logic [7:0] FRAME2     = 8'h80,
  parameter int         PAYLOAD_W  = 17,
  parameter int         BLINK_HALF = 10_000_000
) (
  input  logic      clk,
  input  logic      rstN,
  input  xferStat_t stat,
  output xferCmd_t  cmd,
  output logic      spiEn,
  output logic      ledN
);
  localparam int FRAME_W = 3 * BYTE_W;
  localparam int PAD_W   = FRAME_W - PAYLOAD_W;
  localparam int BLINK_W = $clog2(BLINK_HALF + 1);
  localparam logic [FRAME_W-1:0] FRAME    = {FRAME0, FRAME1, FRAME2};
  // peripheral keeps the last PAYLOAD_W bits and returns them first, pad after
  localparam logic [FRAME_W-1:0] READBACK = {FRAME[PAYLOAD_W-1:0], {PAD_W{1'b0}}};
  localparam logic [FRAME_W-1:0] CHKMASK  = {{PAYLOAD_W{1'b1}}, {PAD_W{1'b0}}};

  seqState_t          state;
  phase_t             phase;
  logic [1:0]         idx;
  logic [BLINK_W-1:0] blinkCnt;

  logic [FRAME_W-1:0] frameSh, expSh, maskSh;
  logic [BYTE_W-1:0]  expByte, maskByte;
  logic               mismatch;

  always_comb begin
    frameSh  = FRAME << (BYTE_W * int'(idx));
    expSh    = READBACK << (BYTE_W * int'(idx));
    maskSh   = CHKMASK << (BYTE_W * int'(idx));
    expByte  = expSh[FRAME_W-1 -: BYTE_W];
    maskByte = maskSh[FRAME_W-1 -: BYTE_W];
    mismatch = |((stat.rxByte ^ expByte) & maskByte);
  end

  assign cmd.load   = (state == ST_LOAD);
  assign cmd.txByte = (phase == PH_CLEAR) ? '0 : frameSh[FRAME_W-1 -: BYTE_W];
  assign spiEn      = (state == ST_ARM) || (state == ST_LOAD) || (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_CLEAR;
      idx      <= '0;
      ledN     <= 1'b1;
      blinkCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: state <= ST_ARM;
        ST_ARM:  state <= ST_LOAD;
        ST_LOAD: state <= ST_WAIT;
        ST_WAIT: begin
          if (stat.done) begin
            if (phase == PH_VERIFY && mismatch) begin
              state    <= ST_FAIL;
              ledN     <= 1'b0;
              blinkCnt <= '0;
            end else if (idx == 2'd2) begin
              state <= ST_CLOSE;
            end else begin
              idx   <= idx + 2'd1;
              state <= ST_LOAD;
            end
          end
        end
        ST_CLOSE: begin
          idx <= '0;
          if (phase == PH_VERIFY) begin
            state <= ST_PASS;
            ledN  <= 1'b0;
          end else begin
            phase <= phase_t'(phase + 2'd1);
            state <= ST_ARM;
          end
        end
        ST_PASS: ledN <= 1'b0;
        ST_FAIL: begin
          if (blinkCnt == BLINK_W'(BLINK_HALF - 1)) begin
            blinkCnt <= '0;
            ledN     <= ~ledN;
          end else begin
            blinkCnt <= blinkCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: bytes are only loaded inside an enabled frame
  p_load_in_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> spiEn);

  // R5: while waiting, the shifter is either working or just finished
  p_wait_tracks_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (stat.busy || stat.done));

  // R7: failure only follows a completed byte of the checking transaction
  p_fail_after_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_FAIL) |-> ($past(stat.done) && phase == PH_VERIFY));

  // R10: pass is terminal with the LED lit
  p_pass_steady_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS) |=> (state == ST_PASS && !ledN));

  // R11: every blink toggle lands on the end of a half period
  p_blink_spacing_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAIL && $past(state) == ST_FAIL && ledN != $past(ledN))
      |-> ($past(blinkCnt) == BLINK_W'(BLINK_HALF - 1)));
endmodule

// File: rtl/spi_verify_seq.sv
module spi_verify_seq
  import spi_verify_pkg::*;
#(
  parameter int         CLK_DIV    = 16,
  parameter int         BLINK_HALF = 10_000_000,
  parameter logic [7:0] FRAME0     = 8'h01,
  parameter logic [7:0] FRAME1     = 8'hFF,
  parameter logic [7:0] FRAME2     = 8'h80
) (
  input  logic clk,
  input  logic rstN,
  input  logic miso,
  output logic sclk,
  output logic mosi,
  output logic spiEn,
  output logic ledN
);
  xferCmd_t  cmd;
  xferStat_t stat;

  spi_seq_ctrl #(
    .FRAME0(FRAME0), .FRAME1(FRAME1), .FRAME2(FRAME2),
    .PAYLOAD_W(17), .BLINK_HALF(BLINK_HALF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .cmd(cmd),
    .spiEn(spiEn), .ledN(ledN)
  );

  spi_shift_dp #(.CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stat(stat),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // R3: no serial clock edge outside an enabled frame
  p_sclk_in_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> spiEn);

  // R9: the enable is only released between bytes
  p_en_drop_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiEn) |-> !stat.busy);
endmodule

// File: tb/tb_spi_verify_seq.sv
`timescale 1ns/1ps
module tb_spi_verify_seq;
  localparam int  CLK_DIV = 16;
  localparam int  BLINK   = 40;
  localparam real CLKP    = 5.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic misoR = 1'b0;
  logic sclk, mosi, spiEn, ledN;

  always #2.5 clk = ~clk;

  spi_verify_seq #(.CLK_DIV(CLK_DIV), .BLINK_HALF(BLINK)) dut (
    .clk(clk), .rstN(rstN), .miso(misoR), .sclk(sclk), .mosi(mosi),
    .spiEn(spiEn), .ledN(ledN)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // peripheral model: 17-bit store, returns stored bits first then 7 pad zeros
  logic [16:0] latched = '0;
  logic [23:0] rdStream = '0;
  logic [23:0] capture = '0;
  logic [23:0] txLog [0:3];
  int txnIdx = 0, riseCount = 0, inCount = 0, timErr = 0, enErr = 0, gapErr = 0;
  int flipPos = -1;
  realtime lastRise = 0;

  always @(posedge spiEn) begin
    rdStream = {latched, 7'b0};
    if (flipPos >= 0) rdStream[23-flipPos] = ~rdStream[23-flipPos];
    capture = '0;
    inCount = 0;
    misoR   = rdStream[23];
  end

  always @(negedge sclk) begin
    if (spiEn) begin
      if ($realtime - lastRise != (CLK_DIV/2) * CLKP) timErr++;
      rdStream = rdStream << 1;
      #1 misoR = rdStream[23];
    end
  end

  always @(posedge sclk) begin
    riseCount++;
    if (!spiEn) enErr++;
    if (inCount % 8 != 0 && $realtime - lastRise != CLK_DIV * CLKP) timErr++;
    if (inCount % 8 == 0 && inCount > 0 && $realtime - lastRise <= CLK_DIV * CLKP) gapErr++;
    lastRise = $realtime;
    capture  = {capture[22:0], mosi};
    inCount++;
  end

  always @(negedge spiEn) begin
    latched = capture[16:0];
    if (txnIdx < 4) txLog[txnIdx] = capture;
    txnIdx++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runCase(input int flip);
    int failByte;
    int expRises;
    int changes;
    int gap;
    logic prevLed;
    flipPos = flip;
    rstN = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(ledN == 1'b1 && spiEn == 1'b0 && sclk == 1'b0 && mosi == 1'b0, "R1 reset outputs",
          {ledN, spiEn, sclk, mosi}, 4'b1000);
    riseCount = 0; txnIdx = 0; timErr = 0; enErr = 0; gapErr = 0;
    latched = 17'h1A5C3;
    rstN = 1'b1;
    @(negedge clk);
    check(ledN == 1'b1 && sclk == 1'b0, "R1 just after reset", {ledN, sclk}, 2'b10);
    repeat (1400) @(negedge clk);

    if (flip < 0 || flip > 16) failByte = -1;
    else failByte = flip / 8;
    expRises = (failByte < 0) ? 72 : 48 + 8 * (failByte + 1);
    if (failByte < 0)
      check(riseCount == expRises, (flip < 0) ? "R10 sclk rises on pass" : "R8 pad bit ignored",
            riseCount, expRises);
    else
      check(riseCount == expRises, (flip < 16) ? "R7 abort point" : "R8 byte2 msb checked",
            riseCount, expRises);
    check(riseCount == expRises || failByte >= 0 || flip < 0, "R6 sample position",
          riseCount, expRises);
    check(spiEn == 1'b0 && txnIdx == 3, "R9 enable released", {spiEn, 8'(txnIdx)}, 9'd3);
    check(timErr == 0, "R2 bit timing", timErr, 0);
    check(enErr == 0, "R3 sclk inside enable", enErr, 0);
    check(gapErr == 0, "R5 byte spacing", gapErr, 0);

    if (flip < 0) begin
      check(txLog[0] == 24'h000000, "R4 clear bytes", txLog[0], 24'h000000);
      check(txLog[1] == 24'h01FF80, "R4 write bytes", txLog[1], 24'h01FF80);
      check(txLog[2] == 24'h01FF80, "R4 verify bytes", txLog[2], 24'h01FF80);
    end

    if (failByte < 0) begin
      changes = 0;
      prevLed = ledN;
      repeat (200) begin
        @(negedge clk);
        if (ledN != prevLed) changes++;
        prevLed = ledN;
      end
      check(ledN == 1'b0 && changes == 0, "R10 steady LED", {ledN, 8'(changes)}, 0);
    end else begin
      prevLed = ledN;
      changes = 0;
      while (ledN == prevLed && changes < 3 * BLINK) begin
        @(negedge clk);
        changes++;
      end
      prevLed = ledN;
      gap = 0;
      while (ledN == prevLed && gap < 3 * BLINK) begin
        @(negedge clk);
        gap++;
      end
      check(gap == BLINK, "R11 blink half period", gap, BLINK);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    runCase(-1);
    for (int p = 0; p < 24; p++) runCase(p);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule